// File: doc/BRIEF.md
# Mode-Selectable Trace Buffer Controller

This block records CPU bus activity into a small on-chip trace memory during a capture session. A session is started by a one-cycle `arm` pulse, which also latches the capture filter and the trigger alignment for the whole session. Four filters are available. Flow mode records source/destination program counter pairs for each change-of-flow event. Loop mode does the same but drops an event that repeats the last recorded source. Detail mode records address/data pairs for ordinary data cycles. Every-PC mode records the address of each opcode fetch. The decoding of change-of-flow events is done elsewhere and arrives on the `cof_*` inputs.

With begin alignment, recording starts in the cycle where the sequencer trigger is seen and stops when the memory is full. With end alignment, recording starts right after arming. The memory is used circularly, and recording stops in the trigger cycle. While `secure` is high nothing is recorded. Once a session has stopped, software pulls the contents out through a single 16-bit window. Each read advances an internal pointer, starting from the oldest entry, upper half first. An entry counter and an overwrite flag report how much is valid.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, `entry_count` is 0 and `wrapped` is 0.
- R2: Mode 0 (flow) stores one entry `{cof_src, cof_dst}` for every cycle with `cof_valid` high inside the capture window.
- R3: Mode 1 (loop) behaves like mode 0, except that an event whose `cof_src` equals the source of the most recently stored entry of the session is not stored.
- R4: Mode 2 (detail) stores `{bus_addr, bus_data}` for every cycle with `bus_valid` high, `bus_free` low and `bus_opfetch` low.
- R5: Mode 3 (every-PC) stores `{bus_addr, 16'h0000}` for every cycle with `bus_valid` and `bus_opfetch` both high.
- R6: With `align_end` low at arming, the capture window opens in the first trigger cycle, which may itself store an entry. The window closes once `DEPTH` entries are stored. Triggers after that are ignored, and `wrapped` stays 0.
- R7: With `align_end` high at arming, the window opens in the cycle after arming and closes after the trigger cycle, which may itself store an entry. Beyond `DEPTH` entries the oldest entry is overwritten. `entry_count` saturates at `DEPTH` and `wrapped` is set.
- R8: While `secure` is high, no entry is stored and `entry_count` does not change.
- R9: After the session stops, `rd_data` shows the oldest entry's upper half. Each `rd_en` pulse steps through upper half, then lower half, then the next entry in age order, wrapping after 2·`DEPTH` words. Reads before the stop do not move the pointer.
- R10: An `arm` pulse clears `entry_count` and `wrapped` on the next edge. The filter and alignment in force for the session are those present at arming, whatever those inputs do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start a new session, latching mode and alignment |
| mode | input | 2 | Capture filter: 0 flow, 1 loop, 2 detail, 3 every-PC |
| align_end | input | 1 | 0 begin at trigger, 1 end at trigger |
| trig | input | 1 | Trigger from the sequencer |
| secure | input | 1 | Secured mode, suppresses recording |
| bus_valid | input | 1 | A bus cycle is present |
| bus_free | input | 1 | Bus cycle is a free cycle |
| bus_opfetch | input | 1 | Bus cycle is an opcode fetch |
| bus_addr | input | WW | Bus address |
| bus_data | input | WW | Bus data |
| cof_valid | input | 1 | A change-of-flow event is present |
| cof_src | input | WW | Source program counter of the event |
| cof_dst | input | WW | Destination program counter of the event |
| rd_en | input | 1 | Window read strobe, advances the read pointer |
| rd_data | output | WW | Window read data |
| entry_count | output | $clog2(DEPTH+1) | Number of valid entries |
| wrapped | output | 1 | An entry has been overwritten this session |

## Verification
The assertions assume that `arm` arrives as a single-cycle pulse, and that `DEPTH` is a power of two of at least two. They also assume that a begin-aligned session is given enough qualifying cycles after its trigger to fill the memory. The bench drives every input at the falling edge from arithmetic patterns of a cycle index. It arms each session with idle bus inputs, then flips `mode` and `align_end` away from the armed values. It reads the window only after the session has stopped. Sessions cover all four filters in both alignments, with secure held off, toggled periodically and held constantly on.

// File: rtl/trc_pkg.sv
// Shared types for the trace capture controller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package trc_pkg;
    typedef enum logic [1:0] {
        TM_FLOW   = 2'd0,
        TM_LOOP   = 2'd1,
        TM_DETAIL = 2'd2,
        TM_PCALL  = 2'd3
    } trc_mode_e;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_WAIT = 2'd1,
        SS_RUN  = 2'd2,
        SS_DONE = 2'd3
    } sess_st_e;
endpackage

// File: rtl/trc_filter.sv
// Capture qualifier: decides per cycle whether the selected mode wants an
// entry and forms the two-word entry. Holds the last stored source for loop
// suppression. Assumes: commit is high only in cycles where hit was high.
module trc_filter
    import trc_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trc_mode_e       mode,
    input  logic            clear,
    input  logic            commit,
    input  logic            bus_valid,
    input  logic            bus_free,
    input  logic            bus_opfetch,
    input  logic [WW-1:0]   bus_addr,
    input  logic [WW-1:0]   bus_data,
    input  logic            cof_valid,
    input  logic [WW-1:0]   cof_src,
    input  logic [WW-1:0]   cof_dst,
    output logic            hit,
    output logic [2*WW-1:0] entry
);
    logic          last_vld;
    logic [WW-1:0] last_src;
    logic          repeat_src;

    assign repeat_src = last_vld && (cof_src == last_src);

    // Select the per-mode qualifier and entry contents.
    always_comb begin
        hit   = 1'b0;
        entry = '0;
        case (mode)
            TM_FLOW: begin
                hit   = cof_valid;
                entry = {cof_src, cof_dst};
            end
            TM_LOOP: begin
                hit   = cof_valid && !repeat_src;
                entry = {cof_src, cof_dst};
            end
            TM_DETAIL: begin
                hit   = bus_valid && !bus_free && !bus_opfetch;
                entry = {bus_addr, bus_data};
            end
            default: begin
                hit   = bus_valid && bus_opfetch;
                entry = {bus_addr, {WW{1'b0}}};
            end
        endcase
    end

    // Remember the source address of the most recent stored flow entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            last_vld <= 1'b0;
            last_src <= '0;
        end else if (commit && (mode == TM_FLOW || mode == TM_LOOP)) begin
            last_vld <= 1'b1;
            last_src <= cof_src;
        end
    end

    // R3: a repeated source in loop mode never produces a stored entry
    a_r3_loop_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_LOOP && commit) |-> !(last_vld && cof_src == last_src));
endmodule

// File: rtl/trc_session.sv
// Session sequencer: idle, waiting for trigger, running, done. Latches the
// mode and alignment at arming and opens the capture window.
// Assumes: arm is a one-cycle pulse; DEPTH >= 2.
module trc_session
    import trc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm,
    input  trc_mode_e mode_in,
    input  logic      align_end_in,
    input  logic      trig,
    input  logic      wr,
    input  logic      fill_last,
    output trc_mode_e mode_q,
    output logic      align_q,
    output logic      window,
    output logic      stop,
    output logic      done
);
    sess_st_e st, st_n;

    assign window = (st == SS_RUN) || (st == SS_WAIT && trig);
    assign done   = (st == SS_DONE);
    assign stop   = (st_n == SS_DONE) && (st != SS_DONE);

    // Next-state selection; arm overrides every state.
    always_comb begin
        st_n = st;
        if (arm) begin
            st_n = align_end_in ? SS_RUN : SS_WAIT;
        end else begin
            case (st)
                SS_WAIT: if (trig) st_n = (wr && fill_last) ? SS_DONE : SS_RUN;
                SS_RUN:  if (align_q ? trig : (wr && fill_last)) st_n = SS_DONE;
                default: st_n = st;
            endcase
        end
    end

    // State register and per-session configuration latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SS_IDLE;
            mode_q  <= TM_FLOW;
            align_q <= 1'b0;
        end else begin
            st <= st_n;
            if (arm) begin
                mode_q  <= mode_in;
                align_q <= align_end_in;
            end
        end
    end

    // R6: waiting for a trigger only happens in begin alignment
    a_r6_wait_begin: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SS_WAIT) |-> !align_q);
    // R9: once stopped, only a new arm leaves the done state
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);
endmodule

// File: rtl/trc_buffer.sv
// Trace memory with circular write pointer, valid-entry counter, overwrite
// flag and window read pointer. Entries are two words wide, read upper half
// first. Assumes: DEPTH is a power of two; rd_go only while stopped.
module trc_buffer #(
    parameter int WW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr,
    input  logic [2*WW-1:0]              wdata,
    input  logic                         stop,
    input  logic                         rd_go,
    output logic [WW-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         wrapped,
    output logic                         fill_last
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [2*WW-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, wr_ptr_nx;
    logic [PW:0]     rd_ptr;
    logic            is_full, wrapped_nx;
    logic [2*WW-1:0] rd_entry;

    assign is_full    = (count == CW'(DEPTH));
    assign fill_last  = (count == CW'(DEPTH - 1));
    assign wr_ptr_nx  = wr ? wr_ptr + 1'b1 : wr_ptr;
    assign wrapped_nx = wrapped || (wr && is_full);
    assign rd_entry   = mem[rd_ptr[PW:1]];
    assign rd_data    = rd_ptr[0] ? rd_entry[WW-1:0] : rd_entry[2*WW-1:WW];

    // Store the entry at the write pointer.
    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wdata;
    end

    // Write pointer, counter and overwrite flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr  <= '0;
            count   <= '0;
            wrapped <= 1'b0;
        end else begin
            wr_ptr  <= wr_ptr_nx;
            wrapped <= wrapped_nx;
            if (wr && !is_full) count <= count + 1'b1;
        end
    end

    // Read pointer: placed at the oldest entry on stop, stepped per read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
        end else if (stop) begin
            rd_ptr <= wrapped_nx ? {wr_ptr_nx, 1'b0} : '0;
        end else if (rd_go) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R7: the counter never exceeds the memory depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7: an overwrite implies a full memory
    a_r7_wrap_full: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |-> is_full);
    // R10: arming empties the memory on the next edge
    a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !wrapped));
endmodule

// File: rtl/trace_capture_ctrl.sv
// Top of the trace capture controller: joins the filter, session sequencer
// and buffer, gates recording with the capture window and secure input.
// Assumes: change-of-flow decoding is done upstream; arm is a pulse.
module trace_capture_ctrl
    import trc_pkg::*;
#(
    parameter int WW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm,
    input  logic [1:0]                   mode,
    input  logic                         align_end,
    input  logic                         trig,
    input  logic                         secure,
    input  logic                         bus_valid,
    input  logic                         bus_free,
    input  logic                         bus_opfetch,
    input  logic [WW-1:0]                bus_addr,
    input  logic [WW-1:0]                bus_data,
    input  logic                         cof_valid,
    input  logic [WW-1:0]                cof_src,
    input  logic [WW-1:0]                cof_dst,
    input  logic                         rd_en,
    output logic [WW-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   entry_count,
    output logic                         wrapped
);
    trc_mode_e       mode_q;
    logic            align_q, window, stop, done, hit, wr, fill_last;
    logic [2*WW-1:0] entry;

    assign wr = window && hit && !secure && !arm;

    trc_session u_session (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .mode_in      (trc_mode_e'(mode)),
        .align_end_in (align_end),
        .trig         (trig),
        .wr           (wr),
        .fill_last    (fill_last),
        .mode_q       (mode_q),
        .align_q      (align_q),
        .window       (window),
        .stop         (stop),
        .done         (done)
    );

    trc_filter #(.WW(WW)) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .clear       (arm),
        .commit      (wr),
        .bus_valid   (bus_valid),
        .bus_free    (bus_free),
        .bus_opfetch (bus_opfetch),
        .bus_addr    (bus_addr),
        .bus_data    (bus_data),
        .cof_valid   (cof_valid),
        .cof_src     (cof_src),
        .cof_dst     (cof_dst),
        .hit         (hit),
        .entry       (entry)
    );

    trc_buffer #(.WW(WW), .DEPTH(DEPTH)) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (arm),
        .wr        (wr),
        .wdata     (entry),
        .stop      (stop),
        .rd_go     (rd_en && done),
        .rd_data   (rd_data),
        .count     (entry_count),
        .wrapped   (wrapped),
        .fill_last (fill_last)
    );

    // R8: secured cycles leave the counter untouched
    a_r8_secure_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (secure && !arm) |=> (entry_count == $past(entry_count)));
    // R6: begin alignment never overwrites
    a_r6_no_wrap_begin: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_q && !arm) |=> !wrapped);
    // R9: a stopped session records nothing more
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> ($stable(entry_count) && $stable(wrapped)));
endmodule

// File: tb/trace_capture_ctrl_tb.sv
// Self-checking bench: runs sessions over every mode, alignment and secure
// pattern, predicting stored entries from the requirements, then reads back.
module trace_capture_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WW         = 16;
    localparam int DEPTH      = 32;
    localparam int CW         = $clog2(DEPTH+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          align_end = 1'b0;
    logic          trig = 1'b0;
    logic          secure = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_free = 1'b0;
    logic          bus_opfetch = 1'b0;
    logic [WW-1:0] bus_addr = '0;
    logic [WW-1:0] bus_data = '0;
    logic          cof_valid = 1'b0;
    logic [WW-1:0] cof_src = '0;
    logic [WW-1:0] cof_dst = '0;
    logic          rd_en = 1'b0;
    logic [WW-1:0] rd_data;
    logic [CW-1:0] entry_count;
    logic          wrapped;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_capture_ctrl #(.WW(WW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .align_end(align_end),
        .trig(trig), .secure(secure), .bus_valid(bus_valid), .bus_free(bus_free),
        .bus_opfetch(bus_opfetch), .bus_addr(bus_addr), .bus_data(bus_data),
        .cof_valid(cof_valid), .cof_src(cof_src), .cof_dst(cof_dst),
        .rd_en(rd_en), .rd_data(rd_data), .entry_count(entry_count), .wrapped(wrapped)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trig = 0; secure = 0; bus_valid = 0; bus_free = 0; bus_opfetch = 0;
        cof_valid = 0; rd_en = 0;
    endtask

    // One session: md filter, ae alignment, trig at cycle ta, secm secure pattern.
    task automatic run_session(int md, bit ae, int ncyc, int ta, int secm, string tag);
        logic [31:0] exp_q[$];
        bit          last_vld = 0;
        logic [15:0] last_src = '0;
        bit          trig_seen = 0, stopped = 0, wrap_e = 0;
        @(negedge clk);
        idle_inputs();
        mode = 2'(md); align_end = ae; arm = 1;
        @(negedge clk);
        arm = 0;
        mode = 2'(md) ^ 2'd3; align_end = !ae;           // R10: later changes ignored
        chk({tag, " R10 count cleared"}, 32'(entry_count), 32'd0);
        chk({tag, " R10 wrapped cleared"}, 32'(wrapped), 32'd0);
        for (int i = 0; i < ncyc; i++) begin
            bit          bv, bf, bo, cv, sc, tg, hit, cap;
            logic [15:0] ba, bd, cs, cd;
            logic [31:0] ent;
            bv = (i % 5) != 4;  bf = (i % 7) == 3;  bo = (i % 3) == 0;
            ba = 16'(16'h1000 + i * 3);  bd = 16'(i * 17) ^ 16'h5a5a;
            cv = (i % 4) == 1;
            cs = 16'(16'h2000 + (i / 8) * 4);  cd = 16'(16'h3000 + i);
            sc = (secm == 2) || (secm == 1 && (i % 6) < 2);
            tg = (i == ta);
            bus_valid = bv; bus_free = bf; bus_opfetch = bo; bus_addr = ba;
            bus_data = bd; cof_valid = cv; cof_src = cs; cof_dst = cd;
            secure = sc; trig = tg;
            case (md)
                0: begin hit = cv; ent = {cs, cd}; end                            // R2
                1: begin hit = cv && !(last_vld && cs == last_src); ent = {cs, cd}; end // R3
                2: begin hit = bv && !bf && !bo; ent = {ba, bd}; end              // R4
                default: begin hit = bv && bo; ent = {ba, 16'h0000}; end          // R5
            endcase
            cap = !stopped && (ae || trig_seen || tg);
            if (cap && hit && !sc) begin                                          // R8
                if (ae && exp_q.size() == DEPTH) begin
                    void'(exp_q.pop_front());
                    wrap_e = 1;                                                   // R7
                end
                exp_q.push_back(ent);
                if (md <= 1) begin last_vld = 1; last_src = cs; end
            end
            if (tg) trig_seen = 1;
            if (!ae && exp_q.size() == DEPTH) stopped = 1;                        // R6
            if (ae && tg) stopped = 1;                                            // R7
            @(negedge clk);
        end
        idle_inputs();
        @(negedge clk);
        chk({tag, " R6/R7 session stopped"}, 32'(stopped), 32'd1);
        chk({tag, " R7 entry count"}, 32'(entry_count), 32'(exp_q.size()));
        chk({tag, " R7 wrapped flag"}, 32'(wrapped), 32'(wrap_e));
        for (int k = 0; k < exp_q.size(); k++) begin
            chk({tag, " R9 upper word"}, 32'(rd_data), 32'(exp_q[k][31:16]));
            rd_en = 1; @(negedge clk); rd_en = 0;
            chk({tag, " R9 lower word"}, 32'(rd_data), 32'(exp_q[k][15:0]));
            rd_en = 1; @(negedge clk); rd_en = 0;
        end
        if (exp_q.size() == DEPTH)
            chk({tag, " R9 pointer wraps to oldest"}, 32'(rd_data), 32'(exp_q[0][31:16]));
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset count", 32'(entry_count), 32'd0);
        chk("R1 reset wrapped", 32'(wrapped), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 count after release", 32'(entry_count), 32'd0);
        run_session(0, 0, 400, 10,  0, "flow/begin");
        run_session(1, 0, 400, 5,   0, "loop/begin");
        run_session(2, 1, 400, 300, 0, "detail/end");
        run_session(3, 1, 60,  40,  0, "pc/end-short");
        run_session(0, 1, 260, 200, 1, "flow/end/secure");
        run_session(2, 0, 400, 3,   1, "detail/begin/secure");
        run_session(3, 0, 400, 0,   0, "pc/begin");
        run_session(1, 1, 300, 250, 0, "loop/end");
        run_session(2, 1, 80,  50,  2, "secure-locked");
        run_session(0, 1, 30,  12,  0, "flow/end-short");
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule